// File: doc/BRIEF.md
# Base-Mapped Local SRAM Controller

This block is a 4 KB on-chip SRAM. A programmable base register places it in a 32-bit address map. On every CPU request the block decides whether the access belongs to the SRAM. An access hits only when all three of these hold:

- the base register is valid;
- the upper address bits match the programmed base;
- the access type is not inhibited by its mask bit.

A hitting read returns the stored word. A hitting write stores the enabled bytes, unless the region is write-protected. In that case nothing is stored and an access error is raised. Accesses that do not hit are left for the rest of the memory system.

A separate control port writes the base register and reads it back. Software can first map and fill the SRAM, then rewrite the register to tighten the protection and mask attributes. Results appear one clock after the request is presented. The array is never cleared, so its contents are undefined until written.

Top module: `lsram_ctrl`

## Requirements
- R1: After reset, the base register reads back 0. With the valid bit (bit 0) at 0, no access hits, and `hit_o`, `err_o` and `rdata_o` stay 0.
- R2: An access can hit only when `addr_i[31:12]` equals base register bits 31:12. Otherwise the access has no effect on the array.
- R3: Base register bits 5..1 are address-space inhibit masks. Each `type_i` code is tied to one mask bit:

  | `type_i` | Access type | Mask bit |
  |---|---|---|
  | 0 | CPU-space / interrupt acknowledge | bit 5 |
  | 1 | Supervisor code | bit 4 |
  | 2 | Supervisor data | bit 3 |
  | 3 | User code | bit 2 |
  | 4 | User data | bit 1 |

  A mask bit of 1 makes its type miss. Codes 5 to 7 never hit.
- R4: A type whose mask bit is 0 hits when the valid bit is set and the address matches.
- R5: On a storing write, `be_i[k]` enables byte lane k (`wdata_i[8k+7:8k]`). Lanes that are not enabled keep their old contents.
- R6: Base register bit 8 is write-protect. When it is 0, a hitting write stores data with `err_o` 0. When it is 1, a hitting write stores nothing and gives `hit_o` 1 with `err_o` 1. `err_o` is never 1 for a read or for an access that misses.
- R7: A hitting read returns the word indexed by `addr_i[11:2]`. `rdata_o` is 0 in every other cycle.
- R8: `hit_o`, `err_o` and `rdata_o` reflect a request in the cycle after `req_i` is sampled high. They are 0 after a cycle with no request.
- R9: Base register readback has these fields; all other bits read as 0:

  | Bits | Field |
  |---|---|
  | 31:12 | Base address |
  | 8 | Write-protect |
  | 5:1 | Inhibit masks |
  | 0 | Valid |

  A register write takes effect for a request presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Base register write strobe |
| cfg_wdata_i | input | 32 | Base register write value |
| cfg_rdata_o | output | 32 | Base register readback |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| type_i | input | 3 | Address-space type code |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| hit_o | output | 1 | Access mapped to the SRAM |
| err_o | output | 1 | Write-protect violation |
| rdata_o | output | 32 | Read data |

## Verification
The assertions check the following on every cycle:
- a request with the valid bit clear, a mismatched tag or a set inhibit mask is never followed by a hit;
- an error always comes with a hit;
- the array's write strobe never rises while protection is on;
- read data is zero whenever no hit is reported.

Only the bench scenarios can show the other behaviours:
- that stored data survives and comes back at the right index;
- that byte lanes merge correctly;
- that a protected write leaves the old word intact;
- that a rewritten base register governs the very next request.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  typedef enum logic [2:0] {
    AS_CPU      = 3'd0,
    AS_SUP_CODE = 3'd1,
    AS_SUP_DATA = 3'd2,
    AS_USR_CODE = 3'd3,
    AS_USR_DATA = 3'd4
  } as_type_e;

  localparam int NUM_AS    = 5;
  localparam int VALID_BIT = 0;
  localparam int MASK_LSB  = 1;
  localparam int WP_BIT    = 8;

  // mask vector bit i guards type code (NUM_AS-1-i)
  function automatic logic as_inhibited(input logic [2:0] code,
                                        input logic [NUM_AS-1:0] mask);
    if (int'(code) >= NUM_AS) return 1'b1;
    return mask[NUM_AS-1-int'(code)];
  endfunction
endpackage

// File: rtl/lsram_base_reg.sv
module lsram_base_reg
  import lsram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 12,
  localparam int TAG_W = ADDR_W - BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] rdata_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              wp_o,
  output logic [NUM_AS-1:0] mask_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o   <= '0;
      wp_o    <= 1'b0;
      mask_o  <= '0;
      valid_o <= 1'b0;
    end else if (we_i) begin
      tag_o   <= wdata_i[ADDR_W-1:BLK_W];
      wp_o    <= wdata_i[WP_BIT];
      mask_o  <= wdata_i[MASK_LSB+:NUM_AS];
      valid_o <= wdata_i[VALID_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[ADDR_W-1:BLK_W]     = tag_o;
    rdata_o[WP_BIT]             = wp_o;
    rdata_o[MASK_LSB+:NUM_AS]   = mask_o;
    rdata_o[VALID_BIT]          = valid_o;
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BLK_W-1:WP_BIT+1] == '0 && rdata_o[WP_BIT-1:MASK_LSB+NUM_AS] == '0); // R9
endmodule

// File: rtl/lsram_hit_dec.sv
module lsram_hit_dec
  import lsram_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        type_i,
  input  logic [TAG_W-1:0]  addr_tag_i,
  input  logic [TAG_W-1:0]  cfg_tag_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_wp_i,
  input  logic [NUM_AS-1:0] cfg_mask_i,
  output logic              hit_o,
  output logic              store_o,
  output logic              err_o,
  output logic              read_o
);
  logic tag_eq, allowed;

  always_comb begin
    tag_eq  = (addr_tag_i == cfg_tag_i);
    allowed = !as_inhibited(type_i, cfg_mask_i);
    hit_o   = req_i && cfg_valid_i && tag_eq && allowed;
    store_o = hit_o && we_i && !cfg_wp_i;
    err_o   = hit_o && we_i && cfg_wp_i;
    read_o  = hit_o && !we_i;
  end
endmodule

// File: rtl/lsram_array.sv
module lsram_array #(
  parameter int WORDS  = 1024,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem_q [WORDS];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem_q[idx_i] <= wdata_i[l*8+:8];
      if (re_i) rd_q <= mem_q[idx_i];
    end

    assign rdata_o[l*8+:8] = rd_q;
  end
endmodule

// File: rtl/lsram_ctrl.sv
module lsram_ctrl
  import lsram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 1024,
  localparam int IDX_W = $clog2(WORDS),
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int BLK_W = IDX_W + OFF_W,
  localparam int TAG_W = ADDR_W - BLK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_wdata_i,
  output logic [ADDR_W-1:0]   cfg_rdata_o,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2:0]          type_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                hit_o,
  output logic                err_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [TAG_W-1:0]  cfg_tag;
  logic              cfg_wp, cfg_valid;
  logic [NUM_AS-1:0] cfg_mask;
  logic              hit_c, store_c, err_c, read_c;
  logic              hit_q, err_q, rd_q;
  logic [DATA_W-1:0] arr_rdata;

  lsram_base_reg #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .tag_o   (cfg_tag),
    .wp_o    (cfg_wp),
    .mask_o  (cfg_mask),
    .valid_o (cfg_valid)
  );

  lsram_hit_dec #(.TAG_W(TAG_W)) u_dec (
    .req_i       (req_i),
    .we_i        (we_i),
    .type_i      (type_i),
    .addr_tag_i  (addr_i[ADDR_W-1:BLK_W]),
    .cfg_tag_i   (cfg_tag),
    .cfg_valid_i (cfg_valid),
    .cfg_wp_i    (cfg_wp),
    .cfg_mask_i  (cfg_mask),
    .hit_o       (hit_c),
    .store_o     (store_c),
    .err_o       (err_c),
    .read_o      (read_c)
  );

  lsram_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (store_c),
    .re_i    (read_c),
    .be_i    (be_i),
    .idx_i   (addr_i[BLK_W-1:OFF_W]),
    .wdata_i (wdata_i),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      err_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      hit_q <= hit_c;
      err_q <= err_c;
      rd_q  <= read_c;
    end
  end

  assign hit_o   = hit_q;
  assign err_o   = err_q;
  assign rdata_o = rd_q ? arr_rdata : '0;

  AST_INVALID_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !cfg_valid |=> !hit_o); // R1
  AST_TAG_MISS_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (addr_i[ADDR_W-1:BLK_W] != cfg_tag) |=> !hit_o); // R2
  AST_MASKED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && as_inhibited(type_i, cfg_mask) |=> !hit_o); // R3
  AST_WP_BLOCKS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_c |-> !cfg_wp); // R6
  AST_ERR_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> hit_o); // R6
  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rdata_o == '0); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !hit_o && !err_o); // R8
endmodule

// File: tb/tb_lsram_ctrl.sv
module tb_lsram_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [2:0]  type_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic        hit_o, err_o;
  logic [31:0] rdata_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  lsram_ctrl dut (.*);

  localparam logic [31:0] BASE = 32'h2000_0000;

  function automatic logic [31:0] cfg_word(logic [19:0] tag, logic wp,
                                           logic [4:0] mask, logic v);
    return {tag, 3'b000, wp, 2'b00, mask, v};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [31:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // drive one request, sample the registered result one cycle later
  task automatic acc(logic w, logic [31:0] a, logic [2:0] t, logic [3:0] be,
                     logic [31:0] d, output logic h, output logic e,
                     output logic [31:0] r);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; type_i = t; be_i = be; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    h = hit_o; e = err_o; r = rdata_o;
  endtask

  task automatic t_reset();
    logic h, e; logic [31:0] r;
    check("R1 cfg", cfg_rdata_o, 32'h0);
    check("R1 hit", {31'b0, hit_o}, 32'h0);
    acc(1'b0, 32'h0000_0000, 3'd2, 4'hF, '0, h, e, r);
    check("R1 invalid miss", {30'b0, h, e}, 32'h0);
    check("R1 rdata", r, 32'h0);
  endtask

  task automatic t_readback();
    cfg(32'hFFFF_FFFF);
    check("R9 readback", cfg_rdata_o, 32'hFFFF_F13F);
    cfg(cfg_word(BASE[31:12], 1'b0, 5'b0, 1'b1));
    check("R9 base", cfg_rdata_o, 32'h2000_0001);
  endtask

  task automatic t_rw();
    logic h, e; logic [31:0] r;
    acc(1'b1, BASE + 32'h10, 3'd2, 4'hF, 32'hA5A5_A5A5, h, e, r);
    check("R6 write hit/err", {30'b0, h, e}, 32'h2);
    check("R7 write rdata", r, 32'h0);
    acc(1'b0, BASE + 32'h10, 3'd2, 4'h0, '0, h, e, r);
    check("R7 read hit", {31'b0, h}, 32'h1);
    check("R7 read data", r, 32'hA5A5_A5A5);
    acc(1'b1, BASE + 32'hFFC, 3'd4, 4'hF, 32'h1357_9BDF, h, e, r);
    acc(1'b0, BASE + 32'hFFC, 3'd0, 4'h0, '0, h, e, r);
    check("R4 top word other type", r, 32'h1357_9BDF);
    acc(1'b0, BASE + 32'h10, 3'd3, 4'h0, '0, h, e, r);
    check("R7 index kept", r, 32'hA5A5_A5A5);
  endtask

  task automatic t_bytes();
    logic h, e; logic [31:0] r;
    acc(1'b1, BASE + 32'h10, 3'd1, 4'b0101, 32'h1122_3344, h, e, r);
    acc(1'b0, BASE + 32'h10, 3'd1, 4'h0, '0, h, e, r);
    check("R5 lane merge", r, 32'hA522_A544);
  endtask

  task automatic t_addr();
    logic h, e; logic [31:0] r;
    acc(1'b0, BASE + 32'h1010, 3'd2, 4'h0, '0, h, e, r);
    check("R2 tag miss", {31'b0, h}, 32'h0);
    check("R7 miss rdata", r, 32'h0);
    acc(1'b1, 32'h2100_0010, 3'd2, 4'hF, 32'hFFFF_FFFF, h, e, r);
    check("R2 miss write no err", {30'b0, h, e}, 32'h0);
    acc(1'b0, BASE + 32'h10, 3'd2, 4'h0, '0, h, e, r);
    check("R2 array untouched", r, 32'hA522_A544);
  endtask

  task automatic t_masks();
    logic h, e; logic [31:0] r;
    for (int c = 0; c < 5; c++) begin
      cfg(cfg_word(BASE[31:12], 1'b0, 5'(1 << (4 - c)), 1'b1));
      acc(1'b0, BASE + 32'h10, 3'(c), 4'h0, '0, h, e, r);
      check($sformatf("R3 mask type %0d", c), {31'b0, h}, 32'h0);
      acc(1'b0, BASE + 32'h10, 3'((c + 1) % 5), 4'h0, '0, h, e, r);
      check($sformatf("R4 unmasked type %0d", (c + 1) % 5), r, 32'hA522_A544);
    end
    cfg(cfg_word(BASE[31:12], 1'b0, 5'b0, 1'b1));
    for (int c = 5; c < 8; c++) begin
      acc(1'b0, BASE + 32'h10, 3'(c), 4'h0, '0, h, e, r);
      check($sformatf("R3 bad code %0d", c), {31'b0, h}, 32'h0);
    end
  endtask

  task automatic t_wp();
    logic h, e; logic [31:0] r;
    cfg(cfg_word(BASE[31:12], 1'b1, 5'b0, 1'b1));
    acc(1'b1, BASE + 32'h10, 3'd2, 4'hF, 32'hDEAD_BEEF, h, e, r);
    check("R6 protected hit/err", {30'b0, h, e}, 32'h3);
    acc(1'b0, BASE + 32'h10, 3'd2, 4'h0, '0, h, e, r);
    check("R6 read no err", {30'b0, h, e}, 32'h2);
    check("R6 data kept", r, 32'hA522_A544);
    acc(1'b1, 32'h3000_0010, 3'd2, 4'hF, 32'h0, h, e, r);
    check("R6 miss write no err", {30'b0, h, e}, 32'h0);
  endtask

  task automatic t_cfg_next();
    logic h, e; logic [31:0] r;
    cfg(cfg_word(BASE[31:12], 1'b0, 5'b0, 1'b0));
    acc(1'b0, BASE + 32'h10, 3'd2, 4'h0, '0, h, e, r);
    check("R9 next-cycle invalid", {31'b0, h}, 32'h0);
    check("R1 invalid rdata", r, 32'h0);
    cfg(cfg_word(BASE[31:12], 1'b0, 5'b0, 1'b1));
    acc(1'b0, BASE + 32'h10, 3'd2, 4'h0, '0, h, e, r);
    check("R9 next-cycle valid", r, 32'hA522_A544);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    @(negedge clk_i);
    check("R8 idle", {30'b0, hit_o, err_o}, 32'h0);
    check("R8 idle rdata", rdata_o, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_readback();
    t_rw();
    t_bytes();
    t_addr();
    t_masks();
    t_wp();
    t_cfg_next();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule